// File: doc/BRIEF.md
# Multicycle Processor Control Sequencer

This block is the control unit of a single-bus, 16-bit multicycle processor. It is a state machine whose outputs come from the current state. Every instruction takes the same three fetch states and one decode state, then follows a fixed chain of execute states and returns to the first fetch state. In each state the block sets which source drives the shared bus, which registers load on the closing clock edge, the settings of the datapath multiplexers, the register-file port selects and write enable, and the memory write enable. Bus values and mux settings are valid during a state, and every register or memory capture happens on the rising edge that ends the state.

The block has three inputs. The decode state reads the 4-bit opcode and bit 11 of the instruction register, and these are the only points where the state sequence branches. The branch execute state uses a separate branch-taken bit, which is computed outside the block, to decide whether the PC loads. Opcodes that have no execute chain here go straight back to fetch.

Top module: `cpuCtrlFsm`

## Requirements
- R1: While `rstN` is low, every output is 0 and the machine returns to the first fetch state. In the first cycle after release, the outputs show the first fetch state.
- R2: Field codes used by the block:
  - `pcSrcSel`: 00 = PC+1, 01 = address adder.
  - `addrOffSel`: 00 = zero, 01 = 6-bit offset, 10 = 9-bit offset, 11 = 11-bit offset.
  - `addrBaseSel`: 0 = PC, 1 = register.
  - `mdrSrcSel`: 1 = memory, 0 = bus.
  - `rfReadSel`: 0 = IR[8:6], 1 = IR[11:9].
  - `drSel`: 0 = IR[11:9], 1 = register 7.
  - `aluOp`: 11 = pass.
  - `marSrcSel` is always 0, meaning the adder.
  
  The fetch takes three cycles:
  - `pcToBus` and `marLoad`.
  - `pcLoad` with `pcSrcSel`=00, plus `mdrLoad` with `mdrSrcSel`=1.
  - `mdrToBus` and `irLoad`.
- R3: The decode cycle asserts no output. It then dispatches on the opcode: 1110 load-effective-address, 0110 register-based load, 1010 indirect load, 0111 register-based store, 1011 indirect store, 0100 subroutine call, 0000 branch.
- R4: Load-effective-address takes one cycle. It drives `addrToBus` with the PC base and the 9-bit offset, and asserts `regWrite` with `drSel`=0.
- R5: Register-based load takes three cycles:
  - Register base plus 6-bit offset on the bus (`rfReadSel`=0) into the MAR.
  - Memory into the MDR.
  - `mdrToBus` with `regWrite`.
- R6: Indirect load takes five cycles:
  - PC plus 9-bit offset into the MAR.
  - Memory into the MDR.
  - `mdrToBus` with `marLoad`.
  - Memory into the MDR.
  - `mdrToBus` with `regWrite`.
- R7: Register-based store takes three cycles:
  - The same first cycle as R5.
  - `rfReadSel`=1 with `aluOp`=11 and `aluToBus`, plus `mdrLoad` with `mdrSrcSel`=0.
  - `memWrite` alone.
- R8: Indirect store takes five cycles. The first three match R6. The fourth matches the second cycle of R7, and the fifth asserts `memWrite` alone.
- R9: With opcode 0100 and IR[11]=0, the call takes two cycles:
  - `pcToBus` with `regWrite` and `drSel`=1.
  - `pcLoad` with `pcSrcSel`=01, register base and offset code 00.
- R10: With opcode 0100 and IR[11]=1, the first cycle is the same as in R9. The second asserts `pcLoad` with `pcSrcSel`=01, PC base and the 11-bit offset.
- R11: The branch takes one cycle with `pcSrcSel`=01, PC base and the 9-bit offset. `pcLoad` equals `brTaken` in that cycle.
- R12: Any opcode not listed in R3 returns from decode directly to the first fetch state.
- R13: Changes to the opcode or IR[11] after the decode cycle do not alter the remaining execute chain.
- R14: At most one of `pcToBus`, `mdrToBus`, `aluToBus` and `addrToBus` is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| opcode | input | 4 | Instruction register bits 15:12 |
| irBit11 | input | 1 | Instruction register bit 11 |
| brTaken | input | 1 | Branch condition met, computed outside the block |
| pcToBus | output | 1 | PC drives the bus |
| mdrToBus | output | 1 | MDR drives the bus |
| aluToBus | output | 1 | ALU drives the bus |
| addrToBus | output | 1 | Address adder/MAR mux drives the bus |
| marLoad | output | 1 | MAR loads at end of cycle |
| mdrLoad | output | 1 | MDR loads at end of cycle |
| irLoad | output | 1 | IR loads at end of cycle |
| pcLoad | output | 1 | PC loads at end of cycle |
| regWrite | output | 1 | Register file write enable |
| memWrite | output | 1 | Memory write enable |
| pcSrcSel | output | 2 | PC input select |
| mdrSrcSel | output | 1 | MDR input select |
| addrBaseSel | output | 1 | Address adder base select |
| addrOffSel | output | 2 | Address adder offset select |
| marSrcSel | output | 1 | MAR-path mux select |
| rfReadSel | output | 1 | Register read address field select |
| drSel | output | 1 | Register write address select |
| aluOp | output | 2 | ALU operation code |

## Verification
The bench runs both subroutine variants back to back. If IR[11] were ignored, the 11-bit offset select would appear where the register base should be, or the reverse. It runs the branch with `brTaken` both high and low; a `pcLoad` that does not follow that input would move the PC on a branch that is not taken. It changes the opcode in the middle of a load chain, and a design that re-decoded after the decode cycle would jump into a store chain. It also checks reset asserted in the middle of a fetch: a design that keeps its state, or that drives the fetch-state outputs while in reset, fails there.

// File: rtl/ctrlPkg.sv
package ctrlPkg;

  localparam int OP_W    = 4;
  localparam int STATE_W = 5;
  localparam int SEL_W   = 2;

  typedef enum logic [STATE_W-1:0] {
    ST_F0, ST_F1, ST_F2, ST_DEC,
    ST_LEA0,
    ST_LDR0, ST_LDR1, ST_LDR2,
    ST_LDI0, ST_LDI1, ST_LDI2, ST_LDI3, ST_LDI4,
    ST_STR0, ST_STR1, ST_STR2,
    ST_STI0, ST_STI1, ST_STI2, ST_STI3, ST_STI4,
    ST_CALLR0, ST_CALLR1,
    ST_CALLO0, ST_CALLO1,
    ST_BR0
  } stateT;

  localparam logic [OP_W-1:0] OPC_BR   = 4'b0000;
  localparam logic [OP_W-1:0] OPC_CALL = 4'b0100;
  localparam logic [OP_W-1:0] OPC_LDR  = 4'b0110;
  localparam logic [OP_W-1:0] OPC_STR  = 4'b0111;
  localparam logic [OP_W-1:0] OPC_LDI  = 4'b1010;
  localparam logic [OP_W-1:0] OPC_STI  = 4'b1011;
  localparam logic [OP_W-1:0] OPC_LEA  = 4'b1110;

  localparam logic [SEL_W-1:0] PC_INC   = 2'b00;
  localparam logic [SEL_W-1:0] PC_ADDER = 2'b01;
  localparam logic [SEL_W-1:0] OFF_NONE = 2'b00;
  localparam logic [SEL_W-1:0] OFF_6    = 2'b01;
  localparam logic [SEL_W-1:0] OFF_9    = 2'b10;
  localparam logic [SEL_W-1:0] OFF_11   = 2'b11;
  localparam logic [SEL_W-1:0] ALU_PASS = 2'b11;
  localparam logic BASE_PC   = 1'b0;
  localparam logic BASE_REG  = 1'b1;
  localparam logic MDR_BUS   = 1'b0;
  localparam logic MDR_MEM   = 1'b1;
  localparam logic RD_LOW    = 1'b0;
  localparam logic RD_HIGH   = 1'b1;
  localparam logic DR_FIELD  = 1'b0;
  localparam logic DR_LINK   = 1'b1;

  typedef struct packed {
    logic             pcToBus;
    logic             mdrToBus;
    logic             aluToBus;
    logic             addrToBus;
    logic             marLoad;
    logic             mdrLoad;
    logic             irLoad;
    logic             pcLoad;
    logic             regWrite;
    logic             memWrite;
    logic [SEL_W-1:0] pcSrcSel;
    logic             mdrSrcSel;
    logic             addrBaseSel;
    logic [SEL_W-1:0] addrOffSel;
    logic             marSrcSel;
    logic             rfReadSel;
    logic             drSel;
    logic [SEL_W-1:0] aluOp;
  } ctrlWordT;

endpackage

// File: rtl/seqCore.sv
module seqCore
  import ctrlPkg::*;
(
  input  logic            clk,
  input  logic            rstN,
  input  logic [OP_W-1:0] opcode,
  input  logic            irBit11,
  output stateT           state
);

  stateT nextState;

  // Only the decode state looks at opcode and irBit11 (R3, R13)
  always_comb begin
    nextState = ST_F0;
    unique case (state)
      ST_F0:     nextState = ST_F1;
      ST_F1:     nextState = ST_F2;
      ST_F2:     nextState = ST_DEC;
      ST_DEC: begin
        unique case (opcode)
          OPC_BR:   nextState = ST_BR0;
          OPC_CALL: nextState = irBit11 ? ST_CALLO0 : ST_CALLR0;
          OPC_LDR:  nextState = ST_LDR0;
          OPC_STR:  nextState = ST_STR0;
          OPC_LDI:  nextState = ST_LDI0;
          OPC_STI:  nextState = ST_STI0;
          OPC_LEA:  nextState = ST_LEA0;
          default:  nextState = ST_F0;   // R12
        endcase
      end
      ST_LDR0:   nextState = ST_LDR1;
      ST_LDR1:   nextState = ST_LDR2;
      ST_LDI0:   nextState = ST_LDI1;
      ST_LDI1:   nextState = ST_LDI2;
      ST_LDI2:   nextState = ST_LDI3;
      ST_LDI3:   nextState = ST_LDI4;
      ST_STR0:   nextState = ST_STR1;
      ST_STR1:   nextState = ST_STR2;
      ST_STI0:   nextState = ST_STI1;
      ST_STI1:   nextState = ST_STI2;
      ST_STI2:   nextState = ST_STI3;
      ST_STI3:   nextState = ST_STI4;
      ST_CALLR0: nextState = ST_CALLR1;
      ST_CALLO0: nextState = ST_CALLO1;
      default:   nextState = ST_F0;     // last state of every chain
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_F0;          // R1
    else       state <= nextState;
  end

endmodule

// File: rtl/ctrlDecode.sv
module ctrlDecode
  import ctrlPkg::*;
(
  input  stateT    state,
  input  logic     brTaken,
  output ctrlWordT cw
);

  always_comb begin
    cw = '0;
    unique case (state)
      ST_F0: begin                         // R2
        cw.pcToBus = 1'b1;
        cw.marLoad = 1'b1;
      end
      ST_F1: begin
        cw.pcSrcSel  = PC_INC;
        cw.pcLoad    = 1'b1;
        cw.mdrSrcSel = MDR_MEM;
        cw.mdrLoad   = 1'b1;
      end
      ST_F2: begin
        cw.mdrToBus = 1'b1;
        cw.irLoad   = 1'b1;
      end
      ST_LEA0: begin                       // R4
        cw.addrBaseSel = BASE_PC;
        cw.addrOffSel  = OFF_9;
        cw.marSrcSel   = 1'b0;
        cw.addrToBus   = 1'b1;
        cw.drSel       = DR_FIELD;
        cw.regWrite    = 1'b1;
      end
      ST_LDR0, ST_STR0: begin              // R5, R7
        cw.rfReadSel   = RD_LOW;
        cw.addrBaseSel = BASE_REG;
        cw.addrOffSel  = OFF_6;
        cw.addrToBus   = 1'b1;
        cw.marLoad     = 1'b1;
      end
      ST_LDI0, ST_STI0: begin              // R6, R8
        cw.addrBaseSel = BASE_PC;
        cw.addrOffSel  = OFF_9;
        cw.addrToBus   = 1'b1;
        cw.marLoad     = 1'b1;
      end
      ST_LDR1, ST_LDI1, ST_LDI3, ST_STI1: begin
        cw.mdrSrcSel = MDR_MEM;
        cw.mdrLoad   = 1'b1;
      end
      ST_LDI2, ST_STI2: begin
        cw.mdrToBus = 1'b1;
        cw.marLoad  = 1'b1;
      end
      ST_LDR2, ST_LDI4: begin
        cw.mdrToBus = 1'b1;
        cw.drSel    = DR_FIELD;
        cw.regWrite = 1'b1;
      end
      ST_STR1, ST_STI3: begin
        cw.rfReadSel = RD_HIGH;
        cw.aluOp     = ALU_PASS;
        cw.aluToBus  = 1'b1;
        cw.mdrSrcSel = MDR_BUS;
        cw.mdrLoad   = 1'b1;
      end
      ST_STR2, ST_STI4: cw.memWrite = 1'b1;
      ST_CALLR0, ST_CALLO0: begin          // R9, R10
        cw.pcToBus  = 1'b1;
        cw.drSel    = DR_LINK;
        cw.regWrite = 1'b1;
      end
      ST_CALLR1: begin                     // R9
        cw.rfReadSel   = RD_LOW;
        cw.addrBaseSel = BASE_REG;
        cw.addrOffSel  = OFF_NONE;
        cw.pcSrcSel    = PC_ADDER;
        cw.pcLoad      = 1'b1;
      end
      ST_CALLO1: begin                     // R10
        cw.addrBaseSel = BASE_PC;
        cw.addrOffSel  = OFF_11;
        cw.pcSrcSel    = PC_ADDER;
        cw.pcLoad      = 1'b1;
      end
      ST_BR0: begin                        // R11
        cw.addrBaseSel = BASE_PC;
        cw.addrOffSel  = OFF_9;
        cw.pcSrcSel    = PC_ADDER;
        cw.pcLoad      = brTaken;
      end
      default: cw = '0;                    // decode state, R3
    endcase
  end

endmodule

// File: rtl/cpuCtrlFsm.sv
module cpuCtrlFsm
  import ctrlPkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic [OP_W-1:0]  opcode,
  input  logic             irBit11,
  input  logic             brTaken,
  output logic             pcToBus,
  output logic             mdrToBus,
  output logic             aluToBus,
  output logic             addrToBus,
  output logic             marLoad,
  output logic             mdrLoad,
  output logic             irLoad,
  output logic             pcLoad,
  output logic             regWrite,
  output logic             memWrite,
  output logic [SEL_W-1:0] pcSrcSel,
  output logic             mdrSrcSel,
  output logic             addrBaseSel,
  output logic [SEL_W-1:0] addrOffSel,
  output logic             marSrcSel,
  output logic             rfReadSel,
  output logic             drSel,
  output logic [SEL_W-1:0] aluOp
);

  stateT    state;
  ctrlWordT cwRaw;
  ctrlWordT cw;

  seqCore i_seqCore (
    .clk    (clk),
    .rstN   (rstN),
    .opcode (opcode),
    .irBit11(irBit11),
    .state  (state)
  );

  ctrlDecode i_ctrlDecode (
    .state  (state),
    .brTaken(brTaken),
    .cw     (cwRaw)
  );

  // Strobes held low while reset is asserted (R1)
  assign cw = rstN ? cwRaw : '0;

  assign pcToBus     = cw.pcToBus;
  assign mdrToBus    = cw.mdrToBus;
  assign aluToBus    = cw.aluToBus;
  assign addrToBus   = cw.addrToBus;
  assign marLoad     = cw.marLoad;
  assign mdrLoad     = cw.mdrLoad;
  assign irLoad      = cw.irLoad;
  assign pcLoad      = cw.pcLoad;
  assign regWrite    = cw.regWrite;
  assign memWrite    = cw.memWrite;
  assign pcSrcSel    = cw.pcSrcSel;
  assign mdrSrcSel   = cw.mdrSrcSel;
  assign addrBaseSel = cw.addrBaseSel;
  assign addrOffSel  = cw.addrOffSel;
  assign marSrcSel   = cw.marSrcSel;
  assign rfReadSel   = cw.rfReadSel;
  assign drSel       = cw.drSel;
  assign aluOp       = cw.aluOp;

  p_one_driver_r14: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({pcToBus, mdrToBus, aluToBus, addrToBus}));

  p_fetch_step_r2: assert property (@(posedge clk) disable iff (!rstN)
    (pcToBus && marLoad) |=> (pcLoad && mdrLoad && mdrSrcSel && pcSrcSel == PC_INC));

  p_decode_quiet_r3: assert property (@(posedge clk) disable iff (!rstN)
    irLoad |=> (cw == '0));

  p_store_data_ready_r7: assert property (@(posedge clk) disable iff (!rstN)
    memWrite |-> $past(mdrLoad && !mdrSrcSel));

  p_load_data_ready_r5: assert property (@(posedge clk) disable iff (!rstN)
    (regWrite && mdrToBus) |-> $past(mdrLoad && mdrSrcSel));

  p_link_then_jump_r9: assert property (@(posedge clk) disable iff (!rstN)
    (regWrite && pcToBus) |=> (pcLoad && pcSrcSel == PC_ADDER));

endmodule

// File: tb/test_cpuCtrlFsm.sv
module test_cpuCtrlFsm;

  localparam int PERIOD = 10;
  localparam int W = 21;

  localparam logic [W-1:0] PCB   = 21'h1 << 20;
  localparam logic [W-1:0] MDRB  = 21'h1 << 19;
  localparam logic [W-1:0] ALUB  = 21'h1 << 18;
  localparam logic [W-1:0] ADRB  = 21'h1 << 17;
  localparam logic [W-1:0] MARL  = 21'h1 << 16;
  localparam logic [W-1:0] MDRL  = 21'h1 << 15;
  localparam logic [W-1:0] IRL   = 21'h1 << 14;
  localparam logic [W-1:0] PCL   = 21'h1 << 13;
  localparam logic [W-1:0] RFW   = 21'h1 << 12;
  localparam logic [W-1:0] MEMW  = 21'h1 << 11;
  localparam logic [W-1:0] PCADD = 21'h1 << 9;
  localparam logic [W-1:0] MMEM  = 21'h1 << 8;
  localparam logic [W-1:0] BREG  = 21'h1 << 7;
  localparam logic [W-1:0] OFF6  = 21'h1 << 5;
  localparam logic [W-1:0] OFF9  = 21'h2 << 5;
  localparam logic [W-1:0] OFF11 = 21'h3 << 5;
  localparam logic [W-1:0] RDHI  = 21'h1 << 3;
  localparam logic [W-1:0] DR7   = 21'h1 << 2;
  localparam logic [W-1:0] PASS  = 21'h3;

  localparam logic [W-1:0] WF0 = PCB | MARL;
  localparam logic [W-1:0] WF1 = PCL | MDRL | MMEM;
  localparam logic [W-1:0] WF2 = MDRB | IRL;
  localparam logic [W-1:0] WMEMRD = MDRL | MMEM;
  localparam logic [W-1:0] WRBASE = ADRB | MARL | BREG | OFF6;
  localparam logic [W-1:0] WPCOFF = ADRB | MARL | OFF9;
  localparam logic [W-1:0] WPASS  = RDHI | PASS | ALUB | MDRL;
  localparam logic [W-1:0] WLINK  = PCB | DR7 | RFW;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [3:0] opcode = 4'b0;
  logic irBit11 = 1'b0;
  logic brTaken = 1'b0;

  logic pcToBus, mdrToBus, aluToBus, addrToBus, marLoad, mdrLoad, irLoad, pcLoad;
  logic regWrite, memWrite, mdrSrcSel, addrBaseSel, marSrcSel, rfReadSel, drSel;
  logic [1:0] pcSrcSel, addrOffSel, aluOp;
  logic [W-1:0] obs;

  int nChecks = 0;
  int nFails = 0;
  bit finished = 1'b0;
  logic [W-1:0] expQ[$];
  string tagQ[$];

  always #(PERIOD/2) clk = ~clk;

  cpuCtrlFsm i_cpuCtrlFsm (
    .clk(clk), .rstN(rstN), .opcode(opcode), .irBit11(irBit11), .brTaken(brTaken),
    .pcToBus(pcToBus), .mdrToBus(mdrToBus), .aluToBus(aluToBus), .addrToBus(addrToBus),
    .marLoad(marLoad), .mdrLoad(mdrLoad), .irLoad(irLoad), .pcLoad(pcLoad),
    .regWrite(regWrite), .memWrite(memWrite), .pcSrcSel(pcSrcSel), .mdrSrcSel(mdrSrcSel),
    .addrBaseSel(addrBaseSel), .addrOffSel(addrOffSel), .marSrcSel(marSrcSel),
    .rfReadSel(rfReadSel), .drSel(drSel), .aluOp(aluOp)
  );

  assign obs = {pcToBus, mdrToBus, aluToBus, addrToBus, marLoad, mdrLoad, irLoad, pcLoad,
                regWrite, memWrite, pcSrcSel, mdrSrcSel, addrBaseSel, addrOffSel,
                marSrcSel, rfReadSel, drSel, aluOp};

  task automatic check(input logic [W-1:0] act, input logic [W-1:0] exp, input string req);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: control word %h, expected %h", req, act, exp);
    end
  endtask

  task automatic pushExp(input logic [W-1:0] w, input string req);
    expQ.push_back(w);
    tagQ.push_back(req);
  endtask

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  // Driver: set inputs and queue fetch and decode words (R2, R3)
  task automatic startInstr(input logic [3:0] op, input logic b11, input logic tk);
    opcode  = op;
    irBit11 = b11;
    brTaken = tk;
    pushExp(WF0, "R2 fetch0");
    pushExp(WF1, "R2 fetch1");
    pushExp(WF2, "R2 fetch2");
    pushExp('0,  "R3 decode");
  endtask

  // Monitor: pops one expected word per cycle
  initial begin
    forever begin
      @(negedge clk);
      if (expQ.size() > 0) begin
        logic [W-1:0] w;
        string t;
        w = expQ.pop_front();
        t = tagQ.pop_front();
        check(obs, w, t);
        check(W'($countones(obs[20:17]) <= 1), W'(1), "R14 single bus driver");
      end
    end
  end

  initial begin
    #(PERIOD * 20000);
    if (!finished) begin
      nFails++;
      $display("FAIL watchdog: run did not complete, actual hung, expected finish");
      $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(obs, '0, "R1 outputs low in reset");
    @(posedge clk); #1;
    rstN = 1'b1;

    // R4 load effective address
    startInstr(4'b1110, 1'b0, 1'b0);
    pushExp(ADRB | OFF9 | RFW, "R4 lea");
    step(5);

    // R5 register-based load
    startInstr(4'b0110, 1'b1, 1'b1);
    pushExp(WRBASE, "R5 ldr addr");
    pushExp(WMEMRD, "R5 ldr read");
    pushExp(MDRB | RFW, "R5 ldr write");
    step(7);

    // R6 indirect load
    startInstr(4'b1010, 1'b0, 1'b0);
    pushExp(WPCOFF, "R6 ldi addr");
    pushExp(WMEMRD, "R6 ldi read1");
    pushExp(MDRB | MARL, "R6 ldi pointer");
    pushExp(WMEMRD, "R6 ldi read2");
    pushExp(MDRB | RFW, "R6 ldi write");
    step(9);

    // R7 register-based store
    startInstr(4'b0111, 1'b0, 1'b0);
    pushExp(WRBASE, "R7 str addr");
    pushExp(WPASS, "R7 str data");
    pushExp(MEMW, "R7 str write");
    step(7);

    // R8 indirect store
    startInstr(4'b1011, 1'b1, 1'b0);
    pushExp(WPCOFF, "R8 sti addr");
    pushExp(WMEMRD, "R8 sti read");
    pushExp(MDRB | MARL, "R8 sti pointer");
    pushExp(WPASS, "R8 sti data");
    pushExp(MEMW, "R8 sti write");
    step(9);

    // R9 call through register
    startInstr(4'b0100, 1'b0, 1'b0);
    pushExp(WLINK, "R9 callr link");
    pushExp(BREG | PCADD | PCL, "R9 callr jump");
    step(6);

    // R10 call with offset
    startInstr(4'b0100, 1'b1, 1'b0);
    pushExp(WLINK, "R10 callo link");
    pushExp(OFF11 | PCADD | PCL, "R10 callo jump");
    step(6);

    // R11 branch taken and not taken
    startInstr(4'b0000, 1'b0, 1'b1);
    pushExp(OFF9 | PCADD | PCL, "R11 branch taken");
    step(5);
    startInstr(4'b0000, 1'b1, 1'b0);
    pushExp(OFF9 | PCADD, "R11 branch not taken");
    step(5);

    // R12 unsupported opcodes return to fetch
    startInstr(4'b0001, 1'b0, 1'b0);
    step(4);
    startInstr(4'b1111, 1'b1, 1'b1);
    step(4);
    startInstr(4'b1000, 1'b0, 1'b0);
    step(4);
    startInstr(4'b1110, 1'b0, 1'b0);
    pushExp(ADRB | OFF9 | RFW, "R12 fetch resumes after unsupported");
    step(5);

    // R13 input change after decode is ignored
    startInstr(4'b0110, 1'b0, 1'b0);
    pushExp(WRBASE, "R13 ldr addr");
    pushExp(WMEMRD, "R13 ldr read");
    pushExp(MDRB | RFW, "R13 ldr write");
    step(4);
    opcode  = 4'b1011;
    irBit11 = 1'b1;
    step(3);
    startInstr(4'b0100, 1'b0, 1'b0);
    pushExp(WLINK, "R13 callr link");
    step(5);
    irBit11 = 1'b1;
    pushExp(BREG | PCADD | PCL, "R13 callr jump unchanged");
    step(1);

    // R1 reset in mid fetch
    startInstr(4'b1010, 1'b0, 1'b0);
    step(2);
    expQ.delete();
    tagQ.delete();
    rstN = 1'b0;
    @(negedge clk);
    check(obs, '0, "R1 outputs low in mid-run reset");
    @(posedge clk); #1;
    rstN = 1'b1;
    startInstr(4'b1110, 1'b0, 1'b0);
    pushExp(ADRB | OFF9 | RFW, "R1 restart from fetch0");
    step(5);

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end

endmodule